// File: doc/BRIEF.md
# Binary Hypercube Message Router Node

This block is one node of a packet network wired as a 12-dimensional binary hypercube of 4096 nodes. Each node has a 12-bit address and one bidirectional link per dimension, and two nodes are linked only when their addresses differ in exactly one bit. The node also serves a group of 16 local processors. It accepts messages from those processors through one injection port and from neighbours on 12 incoming links. It then sends each message either out of the node along one dimension or to a local processor.

The routing decision uses only the exclusive-or of the node's own address and the message's destination address. If they are equal, the message is handed to the local delivery port, and the 4-bit processor index in the message selects the processor. If they differ, the message leaves on the link of the lowest differing dimension. Each hop therefore clears one differing bit, so a route takes as many hops as the Hamming distance between source and destination, and never more than 12. The message word itself is passed on unchanged.

Every input has a single-slot holding register. Each output, the 12 link outputs and the local delivery port, has a fixed-priority arbiter that holds its choice while the receiver stalls. All ports use a valid/ready handshake.

Top module: `hc_router`

## Requirements
- R1: In the first cycle after synchronous reset is released, every output valid is low and every input ready is high.
- R2: Each of the 13 inputs is ready exactly when its holding slot is empty. A message taken on valid and ready fills the slot. The slot empties only when the message is accepted by the output it was routed to.
- R3: A held message whose destination address equals `node_id` is offered on the local delivery port. The word is unchanged, so the receiver finds the processor index in bits 15:12.
- R4: A held message whose destination differs from `node_id` is offered unchanged on link output k, where k is the lowest bit position in which the two differ. Message word layout: bits 11:0 destination node address, bits 15:12 destination processor index, bits 31:16 payload.
- R5: When several held messages want the same output in a cycle, the lowest input number wins. Link inputs are numbered 0 to 11 by dimension, and the injection port is input 12.
- R6: A message that loses arbitration or meets a stalled output stays held and competes again in the next cycle. No message is lost or duplicated.
- R7: While an output shows valid with ready low, it keeps valid high and its message word stable in the next cycle, even if a higher-priority message arrives for it.
- R8: Whenever link output k is valid, destination bit k differs from `node_id` bit k and all lower destination bits equal those of `node_id`. The hop therefore clears exactly one differing bit.
- R9: A message accepted in one cycle is first offered at an output in the following cycle, never in the cycle of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 12 | This node's address |
| inj_valid | input | 1 | Local injection message valid |
| inj_ready | output | 1 | Injection slot empty |
| inj_msg | input | 32 | Injected message word |
| lin_valid | input | 12 | Incoming link valid, one per dimension |
| lin_ready | output | 12 | Incoming link slot empty |
| lin_msg | input | 384 | Incoming link words, link i at bits i*32 +: 32 |
| lout_valid | output | 12 | Outgoing link valid, one per dimension |
| lout_ready | input | 12 | Outgoing link receiver ready |
| lout_msg | output | 384 | Outgoing link words, link k at bits k*32 +: 32 |
| loc_valid | output | 1 | Local delivery valid |
| loc_ready | input | 1 | Local delivery receiver ready |
| loc_msg | output | 32 | Delivered message word |

## Verification
Local delivery and forwarding happen in the same cycle whenever one held message matches the node address and another differs from it. Likewise, a link input and the injection port can both contend for one output while a third message is already locked on a stalled output. The bench sets these up deliberately: a directed step holds a stalled link output while a lower-numbered link makes a competing request, and another injects a self-addressed message alongside forwarded ones. A long random phase then mixes self-addressed, one-bit-off and arbitrary destinations with random back-pressure. A behavioural model keeps one slot per input and a lock per output. Each cycle it predicts every output's valid and word and every input's ready, and compares them with the design.

// File: rtl/hc_pkg.sv
package hc_pkg;

    localparam int HC_DIM    = 12;
    localparam int HC_PROC_W = 4;
    localparam int HC_DATA_W = 16;
    localparam int HC_MSG_W  = HC_DIM + HC_PROC_W + HC_DATA_W;
    localparam int HC_NPORT  = HC_DIM + 1;
    localparam int HC_LOCAL  = HC_DIM;

    typedef logic [HC_DIM-1:0]   hc_addr_t;
    typedef logic [HC_NPORT-1:0] hc_portvec_t;

    // destination address in the low bits, then processor index, then payload
    typedef struct packed {
        logic [HC_DATA_W-1:0] data;
        logic [HC_PROC_W-1:0] proc;
        hc_addr_t             dest;
    } hc_msg_t;

    // isolate the lowest set bit of a port vector
    function automatic hc_portvec_t hc_pick_low(hc_portvec_t v);
        return v & (~v + hc_portvec_t'(1));
    endfunction

    // one-hot output request: lowest differing dimension, or the local port
    function automatic hc_portvec_t hc_route(hc_addr_t dest, hc_addr_t node);
        hc_addr_t    diff;
        hc_portvec_t r;
        diff = dest ^ node;
        if (diff == '0)
            r = hc_portvec_t'(1) << HC_LOCAL;
        else
            r = {1'b0, diff & (~diff + hc_addr_t'(1))};
        return r;
    endfunction

endpackage

// File: rtl/hc_in_buf.sv
module hc_in_buf
    import hc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  hc_addr_t    node_id,
    input  logic        in_valid,
    output logic        in_ready,
    input  hc_msg_t     in_msg,
    input  logic        taken,
    output hc_msg_t     buf_msg,
    output hc_portvec_t req
);

    logic    full_q;
    hc_msg_t msg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            msg_q  <= '0;
        end else if (!full_q) begin
            full_q <= in_valid;
            if (in_valid)
                msg_q <= in_msg;
        end else if (taken) begin
            full_q <= 1'b0;
        end
    end

    always_comb begin
        in_ready = !full_q;
        buf_msg  = msg_q;
        req      = full_q ? hc_route(msg_q.dest, node_id) : '0;
    end

endmodule

// File: rtl/hc_out_arb.sv
module hc_out_arb
    import hc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  hc_portvec_t req,
    input  logic        out_ready,
    output hc_portvec_t grant,
    output logic        out_valid
);

    logic        lock_q;
    hc_portvec_t lock_grant_q;

    always_comb begin
        grant     = lock_q ? lock_grant_q : hc_pick_low(req);
        out_valid = |grant;
    end

    // a stalled offer keeps its source until the receiver takes it
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q       <= 1'b0;
            lock_grant_q <= '0;
        end else begin
            lock_q       <= out_valid && !out_ready;
            lock_grant_q <= grant;
        end
    end

endmodule

// File: rtl/hc_router.sv
module hc_router
    import hc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [HC_DIM-1:0]          node_id,
    input  logic                       inj_valid,
    output logic                       inj_ready,
    input  logic [HC_MSG_W-1:0]        inj_msg,
    input  logic [HC_DIM-1:0]          lin_valid,
    output logic [HC_DIM-1:0]          lin_ready,
    input  logic [HC_DIM*HC_MSG_W-1:0] lin_msg,
    output logic [HC_DIM-1:0]          lout_valid,
    input  logic [HC_DIM-1:0]          lout_ready,
    output logic [HC_DIM*HC_MSG_W-1:0] lout_msg,
    output logic                       loc_valid,
    input  logic                       loc_ready,
    output logic [HC_MSG_W-1:0]        loc_msg
);

    logic        in_valid_a [HC_NPORT];
    logic        in_ready_a [HC_NPORT];
    hc_msg_t     in_msg_a   [HC_NPORT];
    hc_msg_t     buf_msg_a  [HC_NPORT];
    hc_portvec_t req_row    [HC_NPORT];
    hc_portvec_t req_col    [HC_NPORT];
    hc_portvec_t grant_a    [HC_NPORT];
    logic        taken_a    [HC_NPORT];
    logic        out_valid_a[HC_NPORT];
    logic        out_ready_a[HC_NPORT];
    hc_msg_t     out_msg_a  [HC_NPORT];

    // port numbering: 0..HC_DIM-1 are dimensions, HC_LOCAL is the local side
    for (genvar k = 0; k < HC_DIM; k++) begin : g_link
        assign in_valid_a[k]               = lin_valid[k];
        assign in_msg_a[k]                 = hc_msg_t'(lin_msg[k*HC_MSG_W +: HC_MSG_W]);
        assign lin_ready[k]                = in_ready_a[k];
        assign lout_valid[k]               = out_valid_a[k];
        assign lout_msg[k*HC_MSG_W +: HC_MSG_W] = out_msg_a[k];
        assign out_ready_a[k]              = lout_ready[k];
    end

    assign in_valid_a[HC_LOCAL]  = inj_valid;
    assign in_msg_a[HC_LOCAL]    = hc_msg_t'(inj_msg);
    assign inj_ready             = in_ready_a[HC_LOCAL];
    assign loc_valid             = out_valid_a[HC_LOCAL];
    assign loc_msg               = out_msg_a[HC_LOCAL];
    assign out_ready_a[HC_LOCAL] = loc_ready;

    for (genvar i = 0; i < HC_NPORT; i++) begin : g_in
        hc_in_buf u_buf (
            .clk      (clk),
            .rst      (rst),
            .node_id  (node_id),
            .in_valid (in_valid_a[i]),
            .in_ready (in_ready_a[i]),
            .in_msg   (in_msg_a[i]),
            .taken    (taken_a[i]),
            .buf_msg  (buf_msg_a[i]),
            .req      (req_row[i])
        );
    end

    for (genvar j = 0; j < HC_NPORT; j++) begin : g_out
        hc_out_arb u_arb (
            .clk       (clk),
            .rst       (rst),
            .req       (req_col[j]),
            .out_ready (out_ready_a[j]),
            .grant     (grant_a[j]),
            .out_valid (out_valid_a[j])
        );
    end

    // transpose requests; collect departures; steer winners to outputs
    always_comb begin
        for (int j = 0; j < HC_NPORT; j++) begin
            for (int i = 0; i < HC_NPORT; i++)
                req_col[j][i] = req_row[i][j];
        end
        for (int i = 0; i < HC_NPORT; i++) begin
            taken_a[i] = 1'b0;
            for (int j = 0; j < HC_NPORT; j++)
                taken_a[i] = taken_a[i] | (grant_a[j][i] & out_ready_a[j]);
        end
        for (int j = 0; j < HC_NPORT; j++) begin
            out_msg_a[j] = '0;
            for (int i = 0; i < HC_NPORT; i++)
                if (grant_a[j][i])
                    out_msg_a[j] = buf_msg_a[i];
        end
    end

endmodule

// File: rtl/hc_router_chk.sv
module hc_router_chk
    import hc_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [HC_DIM-1:0]          node_id,
    input logic                       inj_valid,
    input logic                       inj_ready,
    input logic [HC_DIM-1:0]          lin_valid,
    input logic [HC_DIM-1:0]          lin_ready,
    input logic [HC_DIM-1:0]          lout_valid,
    input logic [HC_DIM-1:0]          lout_ready,
    input logic [HC_DIM*HC_MSG_W-1:0] lout_msg,
    input logic                       loc_valid,
    input logic                       loc_ready,
    input logic [HC_MSG_W-1:0]        loc_msg
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) && !rst |-> (lout_valid == '0) && !loc_valid && (lin_ready == '1) && inj_ready); // R1

    AST_INJ_FILLS: assert property (@(posedge clk) disable iff (rst)
        inj_valid && inj_ready |=> !inj_ready); // R2

    AST_LOCAL_MATCH: assert property (@(posedge clk) disable iff (rst)
        loc_valid |-> (loc_msg[HC_DIM-1:0] == node_id)); // R3

    AST_LOCAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        loc_valid && !loc_ready |=> loc_valid && $stable(loc_msg)); // R7

    for (genvar k = 0; k < HC_DIM; k++) begin : g_k
        localparam hc_addr_t LOW_MASK = hc_addr_t'((64'd1 << k) - 64'd1);

        AST_FWD_DIM: assert property (@(posedge clk) disable iff (rst)
            lout_valid[k] |-> (lout_msg[k*HC_MSG_W + k] != node_id[k])
                && (((lout_msg[k*HC_MSG_W +: HC_DIM] ^ node_id) & LOW_MASK) == '0)); // R8

        AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
            lout_valid[k] && !lout_ready[k] |=> lout_valid[k]
                && $stable(lout_msg[k*HC_MSG_W +: HC_MSG_W])); // R7

        AST_LINK_FILLS: assert property (@(posedge clk) disable iff (rst)
            lin_valid[k] && lin_ready[k] |=> !lin_ready[k]); // R2
    end

endmodule

bind hc_router hc_router_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .node_id    (node_id),
    .inj_valid  (inj_valid),
    .inj_ready  (inj_ready),
    .lin_valid  (lin_valid),
    .lin_ready  (lin_ready),
    .lout_valid (lout_valid),
    .lout_ready (lout_ready),
    .lout_msg   (lout_msg),
    .loc_valid  (loc_valid),
    .loc_ready  (loc_ready),
    .loc_msg    (loc_msg)
);

// File: tb/hc_router_tb.sv
`timescale 1ns/1ps
module hc_router_tb;

    localparam int D  = 12;
    localparam int W  = 32;
    localparam int NP = D + 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [D-1:0]   node_id = 12'hA5C;
    logic           inj_valid = 1'b0;
    logic           inj_ready;
    logic [W-1:0]   inj_msg = '0;
    logic [D-1:0]   lin_valid = '0;
    logic [D-1:0]   lin_ready;
    logic [D*W-1:0] lin_msg = '0;
    logic [D-1:0]   lout_valid;
    logic [D-1:0]   lout_ready = '1;
    logic [D*W-1:0] lout_msg;
    logic           loc_valid;
    logic           loc_ready = 1'b1;
    logic [W-1:0]   loc_msg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state: one slot per input, one lock per output
    bit          mfull [NP];
    logic [31:0] mmsg  [NP];
    int          mlock [NP];

    always #2 clk = ~clk;

    hc_router u_dut (.*);

    function automatic logic [31:0] mk(logic [11:0] dest, logic [3:0] proc, logic [15:0] data);
        return {data, proc, dest};
    endfunction

    function automatic int exp_route(logic [11:0] dest);
        for (int k = 0; k < D; k++)
            if (dest[k] !== node_id[k]) return k;
        return D;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic out_v(int j);
        return (j < D) ? lout_valid[j] : loc_valid;
    endfunction
    function automatic logic [31:0] out_m(int j);
        return (j < D) ? lout_msg[j*W +: W] : loc_msg;
    endfunction
    function automatic logic out_r(int j);
        return (j < D) ? lout_ready[j] : loc_ready;
    endfunction
    function automatic logic in_r(int i);
        return (i < D) ? lin_ready[i] : inj_ready;
    endfunction
    function automatic logic in_v(int i);
        return (i < D) ? lin_valid[i] : inj_valid;
    endfunction
    function automatic logic [31:0] in_m(int i);
        return (i < D) ? lin_msg[i*W +: W] : inj_msg;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NP; i++) begin
            mfull[i] = 0; mmsg[i] = '0; mlock[i] = -1;
        end
    endtask

    // called at a negedge with stimulus in place; returns at the next negedge
    task automatic run_cycle();
        bit pre [NP];
        #0.3;
        for (int i = 0; i < NP; i++) begin
            pre[i] = mfull[i];
            check(in_r(i) == !mfull[i], "R2 input ready", 32'(in_r(i)), 32'(!mfull[i]));
        end
        for (int j = 0; j < NP; j++) begin
            int w;
            w = mlock[j];
            if (w < 0)
                for (int i = NP - 1; i >= 0; i--)
                    if (mfull[i] && exp_route(mmsg[i][11:0]) == j) w = i;
            check(out_v(j) == (w >= 0), "R6 output valid", 32'(out_v(j)), 32'(w >= 0));
            if (w >= 0) begin
                if (j < D) check(out_m(j) == mmsg[w], "R4 forwarded word", out_m(j), mmsg[w]);
                else       check(out_m(j) == mmsg[w], "R3 delivered word", out_m(j), mmsg[w]);
            end
            if (j < D && out_v(j)) begin
                logic [11:0] dd;
                dd = out_m(j)[11:0] ^ node_id;
                check(dd[j] && ((dd & ((12'd1 << j) - 12'd1)) == 0), "R8 hop clears bit",
                      32'(dd), 32'(12'd1 << j));
            end
            if (w >= 0 && out_r(j)) begin
                mfull[w] = 0; mlock[j] = -1;
            end else if (w >= 0) mlock[j] = w;
            else mlock[j] = -1;
        end
        for (int i = 0; i < NP; i++)
            if (in_v(i) && !pre[i]) begin
                mfull[i] = 1; mmsg[i] = in_m(i);
            end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        lin_valid = '0; inj_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #0.3;
        // R1: first cycle out of reset
        check(lout_valid == '0 && !loc_valid, "R1 outputs idle", 32'({lout_valid, loc_valid}), 0);
        check(lin_ready == '1 && inj_ready, "R1 inputs ready", 32'({lin_ready, inj_ready}), 32'h1FFF);
        @(negedge clk);

        // R9 and R3: self-addressed injection
        inj_valid = 1'b1; inj_msg = mk(node_id, 4'd7, 16'h1234);
        #0.3;
        check(!loc_valid, "R9 no same-cycle offer", 32'(loc_valid), 0);
        run_cycle();
        idle_inputs();
        #0.3;
        check(loc_valid && loc_msg[15:12] == 4'd7, "R3 local delivery index", loc_msg, mk(node_id, 4'd7, 16'h1234));
        run_cycle();

        // R4: boundary dimension 11 and a two-bit difference going out on dimension 3
        inj_valid = 1'b1; inj_msg = mk(node_id ^ 12'h800, 4'd1, 16'hB00B);
        run_cycle();
        idle_inputs();
        lin_valid[6] = 1'b1; lin_msg[6*W +: W] = mk(node_id ^ 12'h088, 4'd2, 16'h0088);
        #0.3;
        check(lout_valid[11] && lout_msg[11*W +: W] == mk(node_id ^ 12'h800, 4'd1, 16'hB00B),
              "R4 dimension 11", lout_msg[11*W +: W], mk(node_id ^ 12'h800, 4'd1, 16'hB00B));
        run_cycle();
        idle_inputs();
        #0.3;
        check(lout_valid[3] && !lout_valid[7], "R4 lowest differing dim", 32'(lout_valid), 32'h008);
        run_cycle();

        // R5 / R6: links 5 and 2 collide on dimension 0, injection also wants it;
        // a self-addressed message on link 8 is delivered in the same cycle
        lin_valid[5] = 1'b1; lin_msg[5*W +: W] = mk(node_id ^ 12'h001, 4'd5, 16'h0005);
        lin_valid[2] = 1'b1; lin_msg[2*W +: W] = mk(node_id ^ 12'h001, 4'd2, 16'h0002);
        lin_valid[8] = 1'b1; lin_msg[8*W +: W] = mk(node_id, 4'd8, 16'h0008);
        inj_valid = 1'b1; inj_msg = mk(node_id ^ 12'h101, 4'd12, 16'h000C);
        run_cycle();
        idle_inputs();
        #0.3;
        check(lout_msg[0 +: W] == mk(node_id ^ 12'h001, 4'd2, 16'h0002), "R5 lowest input wins",
              lout_msg[0 +: W], mk(node_id ^ 12'h001, 4'd2, 16'h0002));
        check(loc_valid && loc_msg[31:16] == 16'h0008, "R3 delivery alongside forward", loc_msg, mk(node_id, 4'd8, 16'h0008));
        run_cycle();
        #0.3;
        check(lout_msg[0 +: W] == mk(node_id ^ 12'h001, 4'd5, 16'h0005), "R6 loser next cycle",
              lout_msg[0 +: W], mk(node_id ^ 12'h001, 4'd5, 16'h0005));
        run_cycle();
        #0.3;
        check(lout_msg[0 +: W] == mk(node_id ^ 12'h101, 4'd12, 16'h000C), "R5 injection last",
              lout_msg[0 +: W], mk(node_id ^ 12'h101, 4'd12, 16'h000C));
        run_cycle();

        // R7: stalled dimension 4 keeps link 9's word when link 1 arrives for it
        lout_ready[4] = 1'b0;
        lin_valid[9] = 1'b1; lin_msg[9*W +: W] = mk(node_id ^ 12'h010, 4'd9, 16'h0909);
        run_cycle();
        idle_inputs();
        lin_valid[1] = 1'b1; lin_msg[1*W +: W] = mk(node_id ^ 12'h010, 4'd1, 16'h0101);
        run_cycle();
        idle_inputs();
        #0.3;
        check(lout_valid[4] && lout_msg[4*W +: W] == mk(node_id ^ 12'h010, 4'd9, 16'h0909),
              "R7 locked word stable", lout_msg[4*W +: W], mk(node_id ^ 12'h010, 4'd9, 16'h0909));
        run_cycle();
        lout_ready[4] = 1'b1;
        run_cycle();
        #0.3;
        check(lout_msg[4*W +: W] == mk(node_id ^ 12'h010, 4'd1, 16'h0101), "R6 held after stall",
              lout_msg[4*W +: W], mk(node_id ^ 12'h010, 4'd1, 16'h0101));
        run_cycle();
        run_cycle();

        // random traffic with back-pressure, compared against the model every cycle
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NP; i++) begin
                logic [11:0] dst;
                int sel;
                sel = $urandom_range(0, 3);
                if (sel == 0)      dst = node_id;
                else if (sel == 1) dst = node_id ^ (12'd1 << $urandom_range(0, D - 1));
                else               dst = 12'($urandom);
                if (i < D) begin
                    lin_valid[i] = ($urandom_range(0, 2) == 0);
                    lin_msg[i*W +: W] = mk(dst, 4'($urandom), 16'($urandom));
                end else begin
                    inj_valid = ($urandom_range(0, 2) == 0);
                    inj_msg = mk(dst, 4'($urandom), 16'($urandom));
                end
            end
            lout_ready = 12'($urandom) | 12'($urandom);
            loc_ready = ($urandom_range(0, 3) != 0);
            run_cycle();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule